// File: doc/BRIEF.md
# Sized Integer ALU with Condition Flags

This block is the add/subtract slice of an integer execution unit. It takes an operation code, an operand size and two operands, along with a one-cycle start strobe. On the clock edge that samples the strobe it registers a sized result, a write-back enable with byte lanes, and a new set of four condition flags: carry, zero, sign and overflow. The flags stay in the block's own flag register until the next operation.

All six operations share one two's-complement adder. Subtraction and compare feed the adder the inverted second operand and a carry-in of one. Increment, decrement and negate use the same adder with constant operands. The operation decides how the carry flag is formed and whether the result is written back. Compare only produces flags.

Top module: `int_alu_flags`

## Requirements
- R1: ADD (op code 0) gives (A + B) mod 2^n, where n is 8, 16 or 32 for size code 0, 1 or 2. Carry is the carry out of bit n-1. The same result and flags are produced whether the operands are read as signed or unsigned.
- R2: SUB (op code 1) gives (A - B) mod 2^n. Carry is set exactly when A < B as unsigned n-bit values, which is a borrow.
- R3: INC (op code 2) and DEC (op code 3) give A + 1 and A - 1 mod 2^n. They update zero, sign and overflow and leave the carry flag at its previous value.
- R4: CMP (op code 5) sets all four flags exactly as SUB would. Write-back enable stays low and the byte-lane enables are 4'b0000.
- R5: NEG (op code 4) gives (0 - A) mod 2^n. Carry is cleared when the sized A is zero and set for any nonzero sized A.
- R6: Zero is set when the sized result is all zeros. Sign is bit n-1 of the result. Operand bits above bit n-1 have no effect on the result or on any flag.
- R7: Overflow is set when the exact signed result of the operation lies outside the signed n-bit range.
- R8: The result is zero-extended above bit n-1. For a written operation the byte-lane enables are 4'b0001 for size 0, 4'b0011 for size 1 and 4'b1111 for size 2.
- R9: Result, write-back, lane enables, flags and the done pulse appear one clock after the edge that samples start. In a cycle without start, done and write-back are low and the flags keep their values.
- R10: Synchronous active-high reset clears the flags, result, write-back, lane enables and done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Execute the presented operation on this edge |
| op | input | 3 | Operation code: 0 ADD, 1 SUB, 2 INC, 3 DEC, 4 NEG, 5 CMP |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| src_a | input | 32 | First operand (the only operand for INC, DEC, NEG) |
| src_b | input | 32 | Second operand |
| result | output | 32 | Registered sized result, zero-extended |
| wb_en | output | 1 | Result is to be written to the destination |
| wb_be | output | 4 | Byte-lane enables for the write-back |
| done | output | 1 | One-cycle pulse marking a completed operation |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_o | output | 1 | Signed overflow flag |

## Verification
The assertions assume that op only carries the six defined codes and size only 0, 1 or 2 whenever start is high. Op codes 6 and 7 and size code 3 have no specified meaning. The stimulus draws op codes and sizes only from those legal sets. It fills the operand bits above the selected size with random values, so that R6's claim that they are ignored is exercised. It also places idle cycles between operations, so the flag-hold rules are checked against both strobed and unstrobed edges.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_INC = 3'd2,
        OP_DEC = 3'd3,
        OP_NEG = 3'd4,
        OP_CMP = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } alu_size_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic o;
    } alu_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              cin;
    } adder_in_t;

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic              cout;
        logic              a_msb;
        logic              b_msb;
        logic              s_msb;
    } adder_out_t;

    // Number of byte lanes covered by a size code
    function automatic int lanes_of(alu_size_e sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_WORD: return 2;
            default: return LANES;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(alu_size_e sz);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (i < lanes_of(sz));
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] data_mask(alu_size_e sz);
        logic [LANES-1:0]  lm;
        logic [DATA_W-1:0] m;
        lm = lane_mask(sz);
        for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{lm[i]}};
        return m;
    endfunction

    // Most significant bit inside the selected size
    function automatic logic top_bit(logic [DATA_W-1:0] v, alu_size_e sz);
        return v[lanes_of(sz)*LANE_W - 1];
    endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
    import alu_flags_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output adder_in_t         add_o
);
    logic [DATA_W-1:0] a_raw;
    logic [DATA_W-1:0] b_raw;
    logic              cin;

    always_comb begin
        a_raw = src_a_i;
        b_raw = src_b_i;
        cin   = 1'b0;
        case (op_i)
            OP_ADD: begin
                b_raw = src_b_i;
                cin   = 1'b0;
            end
            OP_SUB, OP_CMP: begin
                b_raw = ~src_b_i;
                cin   = 1'b1;
            end
            OP_INC: begin
                b_raw = '0;
                cin   = 1'b1;
            end
            OP_DEC: begin
                b_raw = '1;
                cin   = 1'b0;
            end
            OP_NEG: begin
                a_raw = '0;
                b_raw = ~src_a_i;
                cin   = 1'b1;
            end
            default: begin
                b_raw = src_b_i;
                cin   = 1'b0;
            end
        endcase
        add_o.a   = a_raw & mask_i;
        add_o.b   = b_raw & mask_i;
        add_o.cin = cin;
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder
    import alu_flags_pkg::*;
(
    input  adder_in_t         add_i,
    input  alu_size_e         size_i,
    output adder_out_t        add_o
);
    // Operands arrive masked to the size, so the bit just above the
    // size boundary of the wide sum is the boundary carry-out.
    logic [DATA_W:0] full;

    assign full = {1'b0, add_i.a} + {1'b0, add_i.b} + {{DATA_W{1'b0}}, add_i.cin};

    always_comb begin
        add_o.sum   = full[DATA_W-1:0];
        add_o.cout  = full[lanes_of(size_i)*LANE_W];
        add_o.a_msb = top_bit(add_i.a, size_i);
        add_o.b_msb = top_bit(add_i.b, size_i);
        add_o.s_msb = top_bit(full[DATA_W-1:0], size_i);
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flags_pkg::*;
(
    input  alu_op_e           op_i,
    input  alu_flags_t        old_i,
    input  adder_out_t        add_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] src_a_i,
    output logic [DATA_W-1:0] result_o,
    output alu_flags_t        flags_o
);
    logic src_zero;

    assign src_zero = ((src_a_i & mask_i) == '0);

    always_comb begin
        result_o  = add_i.sum & mask_i;
        flags_o.z = (result_o == '0);
        flags_o.s = add_i.s_msb;
        flags_o.o = (add_i.a_msb == add_i.b_msb) && (add_i.s_msb != add_i.a_msb);
        case (op_i)
            OP_ADD:          flags_o.c = add_i.cout;
            OP_SUB, OP_CMP:  flags_o.c = ~add_i.cout;
            OP_INC, OP_DEC:  flags_o.c = old_i.c;
            OP_NEG:          flags_o.c = ~src_zero;
            default:         flags_o.c = add_i.cout;
        endcase
    end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
    import alu_flags_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic              wb_en,
    output logic [LANES-1:0]  wb_be,
    output logic              done,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_o
);
    alu_op_e           op_e;
    alu_size_e         sz_e;
    logic [DATA_W-1:0] mask;
    adder_in_t         add_in;
    adder_out_t        add_out;
    logic [DATA_W-1:0] res_next;
    alu_flags_t        flags_q;
    alu_flags_t        flags_next;
    logic              writes;

    assign op_e   = alu_op_e'(op);
    assign sz_e   = alu_size_e'(size);
    assign mask   = data_mask(sz_e);
    assign writes = (op_e != OP_CMP);

    alu_operand_prep u_prep (
        .op_i    (op_e),
        .mask_i  (mask),
        .src_a_i (src_a),
        .src_b_i (src_b),
        .add_o   (add_in)
    );

    alu_adder u_adder (
        .add_i  (add_in),
        .size_i (sz_e),
        .add_o  (add_out)
    );

    alu_flag_gen u_flags (
        .op_i     (op_e),
        .old_i    (flags_q),
        .add_i    (add_out),
        .mask_i   (mask),
        .src_a_i  (src_a),
        .result_o (res_next),
        .flags_o  (flags_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            result  <= '0;
            wb_en   <= 1'b0;
            wb_be   <= '0;
            done    <= 1'b0;
        end else begin
            done  <= start;
            wb_en <= start && writes;
            if (start) begin
                flags_q <= flags_next;
                result  <= res_next;
                wb_be   <= writes ? lane_mask(sz_e) : '0;
            end else begin
                wb_be   <= '0;
            end
        end
    end

    assign flag_c = flags_q.c;
    assign flag_z = flags_q.z;
    assign flag_s = flags_q.s;
    assign flag_o = flags_q.o;
endmodule

// File: rtl/int_alu_flags_chk.sv
module int_alu_flags_chk
    import alu_flags_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [2:0]        op,
    input logic [1:0]        size,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] result,
    input logic              wb_en,
    input logic [LANES-1:0]  wb_be,
    input logic              done,
    input logic              flag_c,
    input logic              flag_z,
    input logic              flag_s
);
    logic [DATA_W-1:0] be_bits;
    logic              a_sized_zero;

    always_comb begin
        for (int i = 0; i < LANES; i++) be_bits[i*LANE_W +: LANE_W] = {LANE_W{wb_be[i]}};
    end
    assign a_sized_zero = ((src_a & data_mask(alu_size_e'(size))) == '0);

    p_cmp_no_wb_r4: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_CMP) |=> (!wb_en && wb_be == '0));

    p_inc_dec_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (start && (op == OP_INC || op == OP_DEC)) |=> (flag_c == $past(flag_c)));

    p_neg_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_NEG && a_sized_zero) |=> (result == '0 && !flag_c && flag_z));

    p_neg_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        (start && op == OP_NEG && !a_sized_zero) |=> flag_c);

    p_zero_ext_r8: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> ((result & ~be_bits) == '0));

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (flag_z == (result == '0)));

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!done && !wb_en && $stable(flag_c) && $stable(flag_z) && $stable(flag_s)));

    p_wb_needs_done_r9: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    always @(posedge clk) begin
        if (!rst && start) begin
            a_legal_op_r9: assert (op <= 3'd5);
            a_legal_size_r9: assert (size <= 2'd2);
        end
    end
endmodule

bind int_alu_flags int_alu_flags_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op     (op),
    .size   (size),
    .src_a  (src_a),
    .result (result),
    .wb_en  (wb_en),
    .wb_be  (wb_be),
    .done   (done),
    .flag_c (flag_c),
    .flag_z (flag_z),
    .flag_s (flag_s)
);

// File: tb/int_alu_flags_tb.sv
module int_alu_flags_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [31:0] res;
        logic        wb;
        logic [3:0]  be;
        logic        c, z, s, o;
        int          op;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] result;
    logic        wb_en;
    logic [3:0]  wb_be;
    logic        done;
    logic        flag_c, flag_z, flag_s, flag_o;

    int   checks = 0;
    int   fails  = 0;
    exp_t sb_q[$];
    exp_t last;
    logic model_c = 1'b0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_alu_flags u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .size(size),
        .src_a(src_a), .src_b(src_b), .result(result), .wb_en(wb_en),
        .wb_be(wb_be), .done(done), .flag_c(flag_c), .flag_z(flag_z),
        .flag_s(flag_s), .flag_o(flag_o)
    );

    function automatic string req_of(int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2, 3: return "R3";
            4: return "R5";
            default: return "R4";
        endcase
    endfunction

    // Reference model written from the requirements with wide signed math
    function automatic exp_t model(int o, int sz, logic [31:0] a, logic [31:0] b, logic cprev);
        exp_t   e;
        int     n;
        longint m, ua, ub, sa, sb, r, sr, smax, smin;
        n    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        m    = (longint'(1) << n) - 1;
        ua   = longint'(a) & m;
        ub   = longint'(b) & m;
        sa   = (ua >= (longint'(1) << (n-1))) ? ua - (longint'(1) << n) : ua;
        sb   = (ub >= (longint'(1) << (n-1))) ? ub - (longint'(1) << n) : ub;
        smax = (longint'(1) << (n-1)) - 1;
        smin = -(longint'(1) << (n-1));
        case (o)
            0: begin r = ua + ub; e.c = (r > m);   sr = sa + sb; end
            1, 5: begin r = ua - ub; e.c = (ua < ub); sr = sa - sb; end
            2: begin r = ua + 1; e.c = cprev;      sr = sa + 1; end
            3: begin r = ua - 1; e.c = cprev;      sr = sa - 1; end
            default: begin r = -ua; e.c = (ua != 0); sr = -sa; end
        endcase
        r     = r & m;
        e.res = 32'(r);
        e.z   = (r == 0);
        e.s   = r[n-1];
        e.o   = (sr > smax) || (sr < smin);
        e.wb  = (o != 5);
        e.be  = (o == 5) ? 4'b0000 : (sz == 0) ? 4'b0001 : (sz == 1) ? 4'b0011 : 4'b1111;
        e.op  = o;
        return e;
    endfunction

    task automatic drive(int o, int sz, logic [31:0] a, logic [31:0] b);
        exp_t e;
        @(negedge clk);
        e = model(o, sz, a, b, model_c);
        model_c = e.c;
        sb_q.push_back(e);
        start = 1'b1; op = 3'(o); size = 2'(sz); src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
        src_a = $urandom; src_b = $urandom;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: compares outputs shortly after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 64'(done), 64'(0));
                end else begin
                    exp_t e;
                    string rq;
                    e = sb_q.pop_front();
                    rq = req_of(e.op);
                    last = e;
                    check(wb_en == e.wb, (e.op == 5) ? "R4" : "R8", "wb_en", 64'(wb_en), 64'(e.wb));
                    check(wb_be == e.be, (e.op == 5) ? "R4" : "R8", "wb_be", 64'(wb_be), 64'(e.be));
                    if (e.wb)
                        check(result == e.res, rq, "result", 64'(result), 64'(e.res));
                    check(flag_c == e.c, rq, "carry", 64'(flag_c), 64'(e.c));
                    check(flag_z == e.z, "R6", "zero", 64'(flag_z), 64'(e.z));
                    check(flag_s == e.s, "R6", "sign", 64'(flag_s), 64'(e.s));
                    check(flag_o == e.o, "R7", "overflow", 64'(flag_o), 64'(e.o));
                end
            end else if (checks > 0) begin
                // R9: no start on the previous edge, so flags hold and no write
                check(!wb_en, "R9", "idle wb_en", 64'(wb_en), 64'(0));
                check({flag_c, flag_z, flag_s, flag_o} == {last.c, last.z, last.s, last.o},
                      "R9", "idle flags", 64'({flag_c, flag_z, flag_s, flag_o}),
                      64'({last.c, last.z, last.s, last.o}));
            end
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(7));
        last = '{res: '0, wb: 1'b0, be: '0, c: 1'b0, z: 1'b0, s: 1'b0, o: 1'b0, op: 0};
        repeat (3) @(negedge clk);
        // R10: reset state
        check({result, wb_en, wb_be, done, flag_c, flag_z, flag_s, flag_o} == '0, "R10",
              "reset outputs", 64'({wb_en, wb_be, done, flag_c, flag_z, flag_s, flag_o}), 64'(0));
        rst = 1'b0;
        idle(2);

        // R1: carry and signed overflow at each boundary, upper bits junk (R6)
        drive(0, 0, 32'hABCD_FF80, 32'h1234_5680);
        drive(0, 0, 32'h0000_007F, 32'h0000_0001);
        drive(0, 1, 32'h5555_FFFF, 32'h0000_0001);
        drive(0, 2, 32'h7FFF_FFFF, 32'h0000_0001);
        drive(0, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // R2: borrow and overflow
        drive(1, 0, 32'h0000_0000, 32'h0000_0001);
        drive(1, 0, 32'hFF00_0080, 32'h0000_0001);
        drive(1, 1, 32'h0000_1234, 32'hFFFF_1234);
        drive(1, 2, 32'h8000_0000, 32'h0000_0001);
        // R3: carry kept across INC/DEC (set then clear)
        drive(1, 0, 32'h0, 32'h5);
        drive(2, 0, 32'h0000_007F, 32'h0);
        drive(3, 1, 32'h0000_8000, 32'h0);
        drive(0, 0, 32'h1, 32'h1);
        drive(2, 2, 32'hFFFF_FFFF, 32'h0);
        drive(3, 0, 32'h0000_0000, 32'h0);
        // R5: negate of zero and nonzero and most negative
        drive(4, 0, 32'hFFFF_FF00, 32'h0);
        drive(4, 0, 32'h0000_0080, 32'h0);
        drive(4, 1, 32'h0000_0001, 32'h0);
        drive(4, 2, 32'h8000_0000, 32'h0);
        drive(4, 2, 32'h0000_0000, 32'h0);
        // R4: compare equal, less, greater
        drive(5, 0, 32'h0000_0042, 32'h0000_0042);
        drive(5, 1, 32'h0000_0001, 32'h0000_0002);
        drive(5, 2, 32'h8000_0000, 32'h7FFF_FFFF);
        idle(4);

        // Random mix with idle gaps
        for (int k = 0; k < 600; k++) begin
            drive(int'($urandom_range(0, 5)), int'($urandom_range(0, 2)), $urandom, $urandom);
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(4);
        finished = 1'b1;
        if (sb_q.size() != 0) check(1'b0, "R9", "pending items", 64'(sb_q.size()), 64'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule